// File: doc/BRIEF.md
# Protection Region Access Checker

This block decides whether a memory access may proceed under a protection unit with a set of programmable regions, eight by default. Each region is described by one configuration word that holds an enable bit, a size code and a base address. Two packed permission words, one for instruction fetches and one for data accesses, hold a 4-bit permission code per region. The block does no translation: the address that comes out is the address that went in.

An access is presented with a one-cycle `req_valid` strobe. It carries the address, the access kind, a privilege flag and the global protection enable. On the next clock edge the block registers its verdict and pulses `rsp_done` for one cycle. The verdict has two grant flags, read and write, and two fault flags. The fault flags separate an access that hit no region (background fault) from an access that hit a region whose code refuses it (permission fault). The verdict outputs keep their values until the next strobe.

Top module: `mpu_perm_checker`

## Requirements
- R1: When `prot_en` is 0, the result grants both read and write and raises no fault, whatever the region and permission settings are.
- R2: A region whose configuration bit 0 is 0 never matches any address.
- R3: For a region with size code N in configuration bits [5:1], the span is 2^(N+1) bytes. The match compares only the address bits above that span with the configuration word. N=31 matches every 32-bit address.
- R4: When several enabled regions match, the region with the highest index decides the result.
- R5: When protection is on and no enabled region matches, `rsp_bg_fault` is 1 and `rsp_perm_fault`, `rsp_rd_ok` and `rsp_wr_ok` are 0.
- R6: A fetch (`req_kind` = 2) takes its code from `perm_fetch`. Loads (0) and stores (1 or 3) take it from `perm_data`. The code for region i sits at bits [4i+3:4i].
- R7: For a privileged access, code 1, 2 or 3 grants read and write, and code 5 or 6 grants read only.
- R8: For a user access, code 3 grants read and write, and code 2 or 6 grants read only. Code 1 or 5 gives a permission fault with no grants.
- R9: Code 0, code 4 and codes 7 to 15 give a permission fault with no grants, at either privilege level.
- R10: The verdict is registered on the clock edge that samples `req_valid` = 1, and `rsp_done` is high for exactly that following cycle. Without a strobe, the verdict outputs hold their values. After reset, all outputs are 0.
- R11: `rsp_addr` equals the address of the request being answered, in every case, including faults and bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_addr | input | ADDR_W | Access address |
| req_kind | input | 2 | 0 load, 1 or 3 store, 2 fetch |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| prot_en | input | 1 | Global protection enable (0 = bypass) |
| region_cfg | input | NUM_REGIONS*ADDR_W | Region i word at [i*ADDR_W +: ADDR_W]: bit 0 enable, bits [5:1] size code, upper bits base |
| perm_fetch | input | NUM_REGIONS*4 | Fetch permission codes, one nibble per region |
| perm_data | input | NUM_REGIONS*4 | Data permission codes, one nibble per region |
| rsp_done | output | 1 | Verdict-valid pulse |
| rsp_addr | output | ADDR_W | Identity-mapped address |
| rsp_rd_ok | output | 1 | Read granted |
| rsp_wr_ok | output | 1 | Write granted |
| rsp_bg_fault | output | 1 | No region matched |
| rsp_perm_fault | output | 1 | Matching region refused the access |

## Verification
Every verdict output and `rsp_done` is due one clock edge after the strobe. The bench drives a request on a falling edge and lets one rising edge pass. It samples on the following falling edge, where `rsp_done` must be 1 and the verdict must match a reference function written from the requirements. On some requests the bench waits one more cycle with the strobe low. It then checks that `rsp_done` has fallen and the verdict has not changed. The same timing applies to directed cases (overlaps, size code 31, disabled regions, every permission code at both privilege levels) and to seeded random traffic.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_ALT   = 2'd3
   } acc_kind_e;

   typedef struct packed {
      logic bg_fault;
      logic perm_fault;
      logic rd_ok;
      logic wr_ok;
   } verdict_t;

   localparam int unsigned CODE_W   = 4;
   localparam int unsigned SIZE_LSB = 1;
   localparam int unsigned SIZE_W   = 5;

endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] cfg,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   import mpu_chk_pkg::*;

   localparam int unsigned EXT_W = ADDR_W + 1;

   logic [SIZE_W-1:0] size_code;
   logic [EXT_W-1:0]  span_ext;
   logic [EXT_W-1:0]  mask_ext;
   logic [ADDR_W-1:0] keep_mask;

   always_comb begin
      size_code = cfg[SIZE_LSB +: SIZE_W];
      // two-step shift in a wider word so code 31 does not wrap
      span_ext  = ({{ADDR_W{1'b0}}, 1'b1} << size_code) << 1;
      mask_ext  = span_ext - {{ADDR_W{1'b0}}, 1'b1};
      keep_mask = ~mask_ext[ADDR_W-1:0];
      hit       = cfg[0] && (((cfg ^ addr) & keep_mask) == '0);
   end

endmodule

// File: rtl/mpu_region_select.sv
module mpu_region_select #(
   parameter int unsigned NUM_REGIONS = 8,
   localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic [NUM_REGIONS-1:0] hits,
   output logic                   any_hit,
   output logic [IDX_W-1:0]       win_idx
);

   always_comb begin
      any_hit = 1'b0;
      win_idx = '0;
      // ascending scan: later (higher) index overwrites, so it wins
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (hits[i]) begin
            any_hit = 1'b1;
            win_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/mpu_perm_decode.sv
module mpu_perm_decode (
   input  logic [3:0] code,
   input  logic       priv,
   output logic       rd_ok,
   output logic       wr_ok,
   output logic       refused
);

   always_comb begin
      rd_ok   = 1'b0;
      wr_ok   = 1'b0;
      refused = 1'b0;
      unique case (code)
         4'd1: begin
            rd_ok = priv; wr_ok = priv; refused = !priv;
         end
         4'd2: begin
            rd_ok = 1'b1; wr_ok = priv;
         end
         4'd3: begin
            rd_ok = 1'b1; wr_ok = 1'b1;
         end
         4'd5: begin
            rd_ok = priv; refused = !priv;
         end
         4'd6: begin
            rd_ok = 1'b1;
         end
         default: refused = 1'b1;
      endcase
   end

endmodule

// File: rtl/mpu_perm_checker.sv
module mpu_perm_checker #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned NUM_REGIONS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [1:0]                    req_kind,
   input  logic                          req_priv,
   input  logic                          prot_en,
   input  logic [NUM_REGIONS*ADDR_W-1:0] region_cfg,
   input  logic [NUM_REGIONS*4-1:0]      perm_fetch,
   input  logic [NUM_REGIONS*4-1:0]      perm_data,
   output logic                          rsp_done,
   output logic [ADDR_W-1:0]             rsp_addr,
   output logic                          rsp_rd_ok,
   output logic                          rsp_wr_ok,
   output logic                          rsp_bg_fault,
   output logic                          rsp_perm_fault
);
   import mpu_chk_pkg::*;

   localparam int unsigned IDX_W  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
   localparam int unsigned PERM_W = NUM_REGIONS * CODE_W;

   initial begin
      if (ADDR_W < SIZE_LSB + SIZE_W + 1)
         $error("ADDR_W too small to hold enable, size code and base");
      if (NUM_REGIONS < 1 || NUM_REGIONS > 16)
         $error("NUM_REGIONS out of supported range 1..16");
   end

   logic [NUM_REGIONS-1:0] hits;
   logic                   any_hit;
   logic [IDX_W-1:0]       win_idx;
   logic [PERM_W-1:0]      perm_sel;
   logic [CODE_W-1:0]      win_code;
   logic                   dec_rd, dec_wr, dec_refused;
   verdict_t               nxt;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      mpu_region_match #(.ADDR_W(ADDR_W)) match_i (
         .cfg  (region_cfg[g*ADDR_W +: ADDR_W]),
         .addr (req_addr),
         .hit  (hits[g])
      );
   end

   mpu_region_select #(.NUM_REGIONS(NUM_REGIONS)) select_i (
      .hits    (hits),
      .any_hit (any_hit),
      .win_idx (win_idx)
   );

   always_comb begin
      perm_sel = (acc_kind_e'(req_kind) == ACC_FETCH) ? perm_fetch : perm_data;
      win_code = perm_sel[win_idx*CODE_W +: CODE_W];
   end

   mpu_perm_decode decode_i (
      .code    (win_code),
      .priv    (req_priv),
      .rd_ok   (dec_rd),
      .wr_ok   (dec_wr),
      .refused (dec_refused)
   );

   always_comb begin
      if (!prot_en) begin
         nxt = '{bg_fault: 1'b0, perm_fault: 1'b0, rd_ok: 1'b1, wr_ok: 1'b1};
      end else if (!any_hit) begin
         nxt = '{bg_fault: 1'b1, perm_fault: 1'b0, rd_ok: 1'b0, wr_ok: 1'b0};
      end else begin
         nxt = '{bg_fault: 1'b0, perm_fault: dec_refused, rd_ok: dec_rd, wr_ok: dec_wr};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_done       <= 1'b0;
         rsp_addr       <= '0;
         rsp_rd_ok      <= 1'b0;
         rsp_wr_ok      <= 1'b0;
         rsp_bg_fault   <= 1'b0;
         rsp_perm_fault <= 1'b0;
      end else begin
         rsp_done <= req_valid;
         if (req_valid) begin
            rsp_addr       <= req_addr;
            rsp_rd_ok      <= nxt.rd_ok;
            rsp_wr_ok      <= nxt.wr_ok;
            rsp_bg_fault   <= nxt.bg_fault;
            rsp_perm_fault <= nxt.perm_fault;
         end
      end
   end

   // R10
   done_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done == $past(req_valid));

   // R10
   verdict_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable({rsp_addr, rsp_rd_ok, rsp_wr_ok, rsp_bg_fault, rsp_perm_fault}));

   // R1
   bypass_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !prot_en) |=> (rsp_rd_ok && rsp_wr_ok && !rsp_bg_fault && !rsp_perm_fault));

   // R11
   addr_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_addr == $past(req_addr)));

   // R5
   fault_kinds_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_bg_fault && rsp_perm_fault));

   // R9
   fault_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_bg_fault || rsp_perm_fault) |-> (!rsp_rd_ok && !rsp_wr_ok));

   // R7
   write_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wr_ok |-> rsp_rd_ok);

   // R4
   winner_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> hits[win_idx]);

endmodule

// File: tb/mpu_perm_checker_tb.sv
module mpu_perm_checker_tb_top;

   localparam int AW = 32;
   localparam int NR = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic [1:0]      req_kind = '0;
   logic            req_priv = 1'b0;
   logic            prot_en = 1'b0;
   logic [NR*AW-1:0] region_cfg;
   logic [NR*4-1:0] perm_fetch = '0;
   logic [NR*4-1:0] perm_data = '0;
   logic            rsp_done;
   logic [AW-1:0]   rsp_addr;
   logic            rsp_rd_ok, rsp_wr_ok, rsp_bg_fault, rsp_perm_fault;

   logic [AW-1:0]   cfg [NR];

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #4 clk = ~clk;

   always_comb
      for (int i = 0; i < NR; i++) region_cfg[i*AW +: AW] = cfg[i];

   mpu_perm_checker #(.ADDR_W(AW), .NUM_REGIONS(NR)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_kind(req_kind), .req_priv(req_priv), .prot_en(prot_en),
      .region_cfg(region_cfg), .perm_fetch(perm_fetch), .perm_data(perm_data),
      .rsp_done(rsp_done), .rsp_addr(rsp_addr), .rsp_rd_ok(rsp_rd_ok),
      .rsp_wr_ok(rsp_wr_ok), .rsp_bg_fault(rsp_bg_fault), .rsp_perm_fault(rsp_perm_fault));

   // returns {bg, perm, rd, wr, addr}
   function automatic logic [AW+3:0] model(input logic [AW-1:0] a, input logic [1:0] k,
                                           input logic priv, input logic en);
      int hit = -1;
      logic [3:0] code;
      logic [NR*4-1:0] pr;
      if (!en) return {4'b0011, a};
      for (int i = NR - 1; i >= 0; i--) begin
         logic [AW:0] m;
         m = (((AW+1)'(1) << cfg[i][5:1]) << 1) - (AW+1)'(1);
         if (hit < 0 && cfg[i][0] && (((cfg[i] ^ a) & ~m[AW-1:0]) == '0)) hit = i;
      end
      if (hit < 0) return {4'b1000, a};
      pr = (k == 2'd2) ? perm_fetch : perm_data;
      code = pr[hit*4 +: 4];
      case (code)
         4'd1: return priv ? {4'b0011, a} : {4'b0100, a};
         4'd2: return priv ? {4'b0011, a} : {4'b0010, a};
         4'd3: return {4'b0011, a};
         4'd5: return priv ? {4'b0010, a} : {4'b0100, a};
         4'd6: return {4'b0010, a};
         default: return {4'b0100, a};
      endcase
   endfunction

   function automatic logic [AW+3:0] observed();
      return {rsp_bg_fault, rsp_perm_fault, rsp_rd_ok, rsp_wr_ok, rsp_addr};
   endfunction

   task automatic check(input string tag, input logic [AW+3:0] exp, input logic exp_done);
      checks++;
      if (observed() !== exp || rsp_done !== exp_done) begin
         fails++;
         $display("FAIL %s: got done=%b v=%h expected done=%b v=%h",
                  tag, rsp_done, observed(), exp_done, exp);
      end
   endtask

   // drive on falling edge, one rising edge captures, sample at next falling edge
   task automatic access(input string tag, input logic [AW-1:0] a, input logic [1:0] k,
                         input logic priv, input bit hold_check);
      logic [AW+3:0] exp;
      req_addr = a; req_kind = k; req_priv = priv; req_valid = 1'b1;
      exp = model(a, k, priv, prot_en);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, exp, 1'b1);
      if (hold_check) begin
         req_addr = ~a;
         @(posedge clk);
         @(negedge clk);
         check({tag, " R10 hold"}, exp, 1'b0);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed;
      for (int i = 0; i < NR; i++) cfg[i] = '0;
      seed = $urandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset", '0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 bypass ignores refusing settings
      for (int i = 0; i < NR; i++) cfg[i] = 32'h0000_003F;
      perm_data = '0; perm_fetch = '0; prot_en = 1'b0;
      access("R1 bypass", 32'hDEAD_BEEF, 2'd1, 1'b0, 1);
      access("R11 bypass addr", 32'h0000_0004, 2'd2, 1'b0, 0);

      // R5 nothing enabled
      for (int i = 0; i < NR; i++) cfg[i] = 32'h0000_003E;
      prot_en = 1'b1;
      access("R5 no region", 32'h1234_5678, 2'd0, 1'b1, 1);
      access("R2 disabled code31", 32'h0, 2'd1, 1'b1, 0);

      // R3 4 KiB region at 0x1000 (N=11)
      cfg[0] = 32'h0000_1017;
      perm_data = 32'h0000_0063; perm_fetch = 32'h0000_0005;
      access("R3 inside top", 32'h0000_1FFC, 2'd1, 1'b0, 0);
      access("R3 inside base", 32'h0000_1000, 2'd0, 1'b0, 0);
      access("R3 just above", 32'h0000_2000, 2'd0, 1'b1, 0);
      access("R3 just below", 32'h0000_0FFC, 2'd0, 1'b1, 0);

      // R3 N=31 covers everything, R4 higher index wins
      cfg[1] = 32'h0000_003F;
      access("R3 code31 far", 32'hFFFF_FFF0, 2'd1, 1'b0, 0);
      access("R4 overlap", 32'h0000_1004, 2'd1, 1'b1, 0);
      cfg[1] = 32'h0000_003E;
      access("R2 region off", 32'h0000_1004, 2'd1, 1'b0, 0);

      // R6 fetch vs data nibble
      access("R6 fetch priv", 32'h0000_1008, 2'd2, 1'b1, 0);
      access("R6 fetch user", 32'h0000_1008, 2'd2, 1'b0, 0);
      access("R6 data user", 32'h0000_1008, 2'd3, 1'b0, 0);

      // R7 R8 R9 every code at both levels, placed in region 5 nibble
      cfg[5] = 32'h0000_1017;
      for (int c = 0; c < 16; c++) begin
         perm_data = 32'h0000_0003 | (32'(c) << 20);
         access("R7 code priv", 32'h0000_1100, 2'd0, 1'b1, 0);
         access("R8 R9 code user", 32'h0000_1100, 2'd1, 1'b0, 0);
      end

      // random traffic
      for (int it = 0; it < 600; it++) begin
         if (it % 25 == 0) begin
            for (int i = 0; i < NR; i++) begin
               logic [4:0] n;
               n = ($urandom % 4 == 0) ? 5'($urandom) : 5'(8 + $urandom % 12);
               cfg[i] = ($urandom & 32'hFFFF_FFC0) | {26'd0, n, 1'($urandom % 4 != 0)};
            end
            perm_data  = $urandom;
            perm_fetch = $urandom;
            prot_en    = ($urandom % 8 != 0);
         end
         begin
            logic [AW-1:0] a;
            a = ($urandom % 2) ? (cfg[$urandom % NR] ^ ($urandom & 32'h0000_FFFF)) : $urandom;
            access("R4 R6 R7 R8 random", a, 2'($urandom), 1'($urandom), ($urandom % 10 == 0));
         end
      end

      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule